// File: doc/BRIEF.md
# Keypad and Input Event Queue

The block sits between a key scanner (or the general-purpose input and logic monitors) and a host register interface. It takes one decoded event per clock as a 7-bit code plus a state bit with a valid strobe, filters it, and stores it as a one-byte record in a 16-deep queue. The queue is oldest-first. The host can look at any slot through an address. It removes the oldest record with a pop strobe, and the records behind it then move one place toward the head.

Key codes are formed upstream as row*5 + column + 1, so the key at row 0, column 0 is code 1. Codes up to 36 belong to keys and are always stored. Codes 37 to 48 come from input and logic sources. Each of these codes is stored only when its own enable bit is set. Code 0 means "no event", and every slot that holds no record reads 0.

A pending count reports how full the queue is. An event interrupt is raised when a record is stored and stays raised while records are pending. A sticky overflow flag records any event that was lost because the queue was full. The host clears the flag by writing a 1 to it.

Top module: `event_queue`

## Requirements
- R1: After reset, count is 0, irq is 0, ovf is 0 and every slot reads 0x00.
- R2: A record is {state, code}: bit 7 of rd_data is the state (1 = pressed/active) and bits 6:0 are the code. Slot 0 holds the oldest record and slot count-1 holds the newest.
- R3: A valid event with a code from 1 to 36 is always stored.
- R4: A valid event with a code from 37 to 48 is stored only when src_en[code-37] is 1. Otherwise the count does not change.
- R5: A valid event with code 0, or with a code above 48, is ignored.
- R6: A pop removes slot 0 and shifts every other slot down by one place. Slots at index count and above read 0. A pop while the queue is empty has no effect.
- R7: count ranges from 0 to 16. A push and a pop in the same cycle leave count unchanged, and the new record is placed after the remaining ones.
- R8: An event that would be stored while count is 16 is dropped, even if a pop happens in the same cycle, and ovf is set. ovf stays set until ovf_clr is pulsed. If a drop and ovf_clr happen in the same cycle, ovf is set.
- R9: irq rises in the cycle after a record is stored. irq_clr clears irq only when count is 0, and it has no effect while records are pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event strobe |
| ev_state | input | 1 | Event state, 1 = pressed/active |
| ev_code | input | 7 | Event code |
| src_en | input | 12 | Per-source enables for codes 37..48 |
| pop | input | 1 | Remove the oldest record |
| rd_addr | input | 4 | Slot to read |
| rd_data | output | 8 | Record in the addressed slot |
| count | output | 5 | Number of pending records |
| ovf | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears ovf |
| irq | output | 1 | Event interrupt |
| irq_clr | input | 1 | Clears irq when the queue is empty |

## Verification
Everything here is registered once, so a wrong internal state shows at the ports on the first sampling point after the edge that caused it. A wrong filter decision or a wrong count shows at once on count. A shift that drops or duplicates a record shows at slot 0 on the next pop. An incorrect zero-fill becomes visible when a slot at or beyond count is read. A wrong interrupt or overflow rule shows as a flag that is set or cleared in the wrong cycle, because both flags are held between the events that change them.

// File: rtl/event_queue.sv
module event_queue #(
  parameter int DEPTH    = 16,
  parameter int CODE_W   = 7,
  parameter int NUM_SRC  = 12,
  parameter int SRC_BASE = 37,
  parameter int KEY_LAST = 36
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ev_valid,
  input  logic                         ev_state,
  input  logic [CODE_W-1:0]            ev_code,
  input  logic [NUM_SRC-1:0]           src_en,
  input  logic                         pop,
  input  logic [$clog2(DEPTH)-1:0]     rd_addr,
  output logic [CODE_W:0]              rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         ovf,
  input  logic                         ovf_clr,
  output logic                         irq,
  input  logic                         irq_clr
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int REC_W = CODE_W + 1;

  logic [REC_W-1:0] slot [DEPTH];
  logic             src_ok;

  always_comb begin
    src_ok = 1'b0;
    for (int j = 0; j < NUM_SRC; j++)
      if (ev_code == CODE_W'(SRC_BASE + j) && src_en[j]) src_ok = 1'b1;
  end

  wire is_key = (ev_code != '0) && (ev_code <= CODE_W'(KEY_LAST));
  wire accept = ev_valid && (is_key || src_ok);
  wire full   = (count == CNT_W'(DEPTH));
  wire push   = accept && !full;
  wire drop   = accept && full;
  wire do_pop = pop && (count != '0);
  wire [CNT_W-1:0] wr_idx = count - CNT_W'(do_pop);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [REC_W-1:0] shifted;
    if (i < DEPTH - 1) begin : g_mid
      assign shifted = do_pop ? slot[i+1] : slot[i];
    end else begin : g_last
      assign shifted = do_pop ? '0 : slot[i];
    end
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                slot[i] <= '0;
      else if (push && wr_idx == CNT_W'(i))      slot[i] <= {ev_state, ev_code};
      else                                       slot[i] <= shifted;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      count <= count + CNT_W'(push) - CNT_W'(do_pop);
      if (drop)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      if (push)                             irq <= 1'b1;
      else if (irq_clr && count == '0)      irq <= 1'b0;
    end

  assign rd_data = slot[rd_addr];

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R7
  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |-> irq); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (count == CNT_W'(DEPTH))); // R8
  AST_POP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !push) |=> (slot[0] == $past(slot[1]))); // R6
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (slot[0] == '0)); // R6
endmodule

// File: tb/event_queue_test.sv
module event_queue_test;
  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ev_state = 0, pop = 0, ovf_clr = 0, irq_clr = 0;
  logic [6:0] ev_code = 0;
  logic [11:0] src_en = 12'h005;
  logic [3:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic [4:0] count;
  logic ovf, irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  event_queue uut (.clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_state(ev_state),
    .ev_code(ev_code), .src_en(src_en), .pop(pop), .rd_addr(rd_addr), .rd_data(rd_data),
    .count(count), .ovf(ovf), .ovf_clr(ovf_clr), .irq(irq), .irq_clr(irq_clr));

  // {valid, state, code[6:0], pop, exp_count[4:0], exp_head[7:0]}
  localparam logic [22:0] VEC [13] = '{
    {1'b1, 1'b1, 7'd1,  1'b0, 5'd1, 8'h81},  // R3
    {1'b1, 1'b0, 7'd36, 1'b0, 5'd2, 8'h81},  // R3
    {1'b1, 1'b1, 7'd37, 1'b0, 5'd3, 8'h81},  // R4 enabled
    {1'b1, 1'b1, 7'd38, 1'b0, 5'd3, 8'h81},  // R4 disabled
    {1'b1, 1'b1, 7'd0,  1'b0, 5'd3, 8'h81},  // R5
    {1'b1, 1'b1, 7'd49, 1'b0, 5'd3, 8'h81},  // R5
    {1'b0, 1'b0, 7'd0,  1'b1, 5'd2, 8'h24},  // R6
    {1'b1, 1'b1, 7'd39, 1'b1, 5'd2, 8'hA5},  // R7
    {1'b0, 1'b0, 7'd0,  1'b1, 5'd1, 8'hA7},  // R2
    {1'b0, 1'b0, 7'd0,  1'b1, 5'd0, 8'h00},  // R6
    {1'b0, 1'b0, 7'd0,  1'b1, 5'd0, 8'h00},  // R6 empty pop
    {1'b1, 1'b0, 7'd5,  1'b0, 5'd1, 8'h05},  // R2
    {1'b0, 1'b0, 7'd0,  1'b1, 5'd0, 8'h00}   // R6
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic v, logic s, logic [6:0] c, logic p);
    @(negedge clk);
    ev_valid = v; ev_state = s; ev_code = c; pop = p;
    @(negedge clk);
    ev_valid = 0; pop = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    chk("R1 count", count, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ovf", ovf, 0);
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a); #1;
      chk("R1 slot", rd_data, 0);
    end
    rd_addr = 0;

    for (int k = 0; k < 13; k++) begin
      @(negedge clk);
      {ev_valid, ev_state, ev_code, pop} = VEC[k][22:13];
      @(negedge clk);
      ev_valid = 0; pop = 0;
      chk($sformatf("R2-vec%0d count", k), count, int'(VEC[k][12:8]));
      chk($sformatf("R2-vec%0d head", k), rd_data, int'(VEC[k][7:0]));
    end

    // R9 interrupt rules
    do_reset();
    cyc(1, 1, 7'd7, 0);
    chk("R9 irq after push", irq, 1);
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk("R9 irq held while pending", irq, 1);
    cyc(0, 0, 0, 1);
    chk("R9 irq held after empty", irq, 1);
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk("R9 irq cleared", irq, 0);

    // R8 overflow, R6 zero fill, R2 ordering
    do_reset();
    for (int k = 1; k <= 16; k++) cyc(1, 0, 7'(k), 0);
    chk("R7 count full", count, 16);
    rd_addr = 15; #1;
    chk("R2 newest at slot 15", rd_data, 16);
    cyc(1, 1, 7'd20, 0);
    chk("R8 drop count", count, 16);
    chk("R8 ovf set", ovf, 1);
    chk("R8 slot 15 kept", rd_data, 16);
    cyc(1, 1, 7'd21, 1);
    chk("R8 drop with pop", count, 15);
    chk("R6 vacated slot zero", rd_data, 0);
    rd_addr = 0; #1;
    chk("R6 head after pop", rd_data, 2);
    @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    chk("R8 ovf cleared", ovf, 0);
    cyc(1, 0, 7'd22, 0);
    chk("R7 refill", count, 16);
    @(negedge clk);
    ev_valid = 1; ev_code = 7'd23; ovf_clr = 1;
    @(negedge clk);
    ev_valid = 0; ovf_clr = 0;
    chk("R8 set wins over clear", ovf, 1);
    @(negedge clk);
    chk("R8 ovf sticky", ovf, 1);

    // R4 enable change
    do_reset();
    src_en = 12'h800;
    cyc(1, 1, 7'd48, 0);
    chk("R4 code 48 enabled", count, 1);
    cyc(1, 1, 7'd37, 0);
    chk("R4 code 37 disabled", count, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule